// File: doc/BRIEF.md
# Banked-Register 4-bit Accumulator Datapath

This block is the execution core of a small nibble-wide processor. It holds a 4-bit accumulator, a carry flag and sixteen 4-bit scratch registers. Registers 0 to 7 exist twice, and a bank flag picks which copy is visible. Registers 8 to 15 are the same in both banks. Each cycle in which `exec_en` is high, the block carries out the operation given on `op` against the register that `reg_sel` names. The new accumulator and carry are visible on the outputs one clock later.

An instruction decoder upstream drives the block. The decoder owns fetch, sequencing and memory traffic, and it drives `exec_en` only for instructions that belong to this datapath. For the immediate-load operation, the `reg_sel` field carries the literal value instead of a register number. The logic operations ignore `reg_sel` and always read one fixed register.

Top module: `acc4_core`

## Requirements
- R1: After reset the accumulator is 0, carry is 0, bank 0 is selected, and every register in both banks reads 0.
- R2: While `exec_en` is 0, the accumulator, the carry, the bank flag and all registers keep their values, whatever `op` and `reg_sel` carry.
- R3: LDI (op 1) puts `reg_sel` into the accumulator. LD (op 2) puts the selected register into the accumulator. Both leave carry unchanged.
- R4: XCH (op 3) writes the old accumulator into the selected register and the old register value into the accumulator, in the same cycle. Carry is unchanged.
- R5: ADD (op 4) sets the 5-bit value {carry, acc} to acc + reg + carry. The register keeps its value.
- R6: SUB (op 5) sets {carry, acc} to acc + (ones complement of reg) + carry. A carry of 1 means no borrow and a carry of 0 means a borrow.
- R7: INC (op 6) adds 1 to the selected register and wraps 15 to 0. The accumulator and carry keep their values.
- R8: ORA (op 7) and ORB (op 8) OR register 4 or register 5 into the accumulator. ANDA (op 9) and ANDB (op 10) AND register 6 or register 7 into it. Registers 4 to 7 are read through the current bank. `reg_sel` is ignored and carry is unchanged.
- R9: CONV (op 11) maps the accumulator as follows: 0000→0000, 0001→0001, 0010→0010, 0100→0011, 1000→0100, and any other value→1111. Carry is unchanged.
- R10: BANK0 (op 12) and BANK1 (op 13) select the bank. With bank 1, register numbers 0 to 7 reach a second set of storage. Numbers 8 to 15 reach the same storage in both banks.
- R11: CLRC (op 14) clears the carry and SETC (op 15) sets it. The accumulator keeps its value.
- R12: NOP (op 0) changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| exec_en | input | 1 | Execute the operation on `op` in this cycle |
| op | input | 4 | Operation code (see R3 to R12) |
| reg_sel | input | 4 | Register number, or the literal for LDI |
| acc | output | 4 | Accumulator |
| carry | output | 1 | Carry / not-borrow flag |

## Verification
Two things can happen in one cycle: a register write and an accumulator update. Under XCH, both touch the same register, which is read and replaced on the same edge. A bank switch can also be followed in the very next cycle by an access to a banked register. Directed sequences provoke both cases: exchanges on registers that were just written, and loads issued immediately after BANK0 or BANK1. A long run of seeded random operations then mixes them freely, with `exec_en` sometimes low. Each result is compared against a bench model that keeps the two banks and the shared half in separate arrays, and register contents are read back through later LD and XCH operations.

// File: rtl/acc_pkg.sv
package acc_pkg;
  parameter int unsigned DW = 4;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LDI   = 4'd1,
    OP_LD    = 4'd2,
    OP_XCH   = 4'd3,
    OP_ADD   = 4'd4,
    OP_SUB   = 4'd5,
    OP_INC   = 4'd6,
    OP_OR_A  = 4'd7,
    OP_OR_B  = 4'd8,
    OP_AND_A = 4'd9,
    OP_AND_B = 4'd10,
    OP_CONV  = 4'd11,
    OP_BANK0 = 4'd12,
    OP_BANK1 = 4'd13,
    OP_CLRC  = 4'd14,
    OP_SETC  = 4'd15
  } op_e;

  // sum with carry in, carry out in the top bit
  function automatic logic [DW:0] add_ci(input logic [DW-1:0] a,
                                         input logic [DW-1:0] b,
                                         input logic ci);
    return {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, ci};
  endfunction

  // subtract: ones complement operand, carry high means no borrow
  function automatic logic [DW:0] sub_nb(input logic [DW-1:0] a,
                                         input logic [DW-1:0] b,
                                         input logic ci);
    return add_ci(a, ~b, ci);
  endfunction

  // one-hot position to number (1-based), zero stays zero, else all ones
  function automatic logic [DW-1:0] onehot_code(input logic [DW-1:0] a);
    logic [DW-1:0] r;
    r = '1;
    if (a == '0) r = '0;
    for (int i = 0; i < int'(DW); i++) begin
      if (a == (DW'(1) << i)) r = DW'(i + 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/acc_rf.sv
module acc_rf #(
  parameter int unsigned DW    = 4,
  parameter int unsigned NREG  = 16,
  parameter int unsigned NBANK = 8,
  localparam int unsigned AW    = $clog2(NREG),
  localparam int unsigned NPHYS = NREG + NBANK,
  localparam int unsigned PW    = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bank,
  input  logic [AW-1:0] sel,
  output logic [DW-1:0] rd_data,
  input  logic          we,
  input  logic [DW-1:0] wdata
);
  logic [DW-1:0] mem [NPHYS];
  logic [PW-1:0] phys;

  // banked numbers in bank 1 live above the primary set
  always_comb begin
    if (bank && (int'(sel) < int'(NBANK))) phys = PW'(sel) + PW'(NREG);
    else                                   phys = PW'(sel);
  end

  assign rd_data = mem[phys];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NPHYS); i++) mem[i] <= '0;
    end else if (we) begin
      mem[phys] <= wdata;
    end
  end

  // a write is visible on the next read of the same physical entry
  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (($past(phys) != phys) || (rd_data == $past(wdata))));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  op_e           opc,
  input  logic [W-1:0]  acc_q,
  input  logic          carry_q,
  input  logic [W-1:0]  rd,
  input  logic [W-1:0]  imm,
  output logic [W-1:0]  acc_n,
  output logic          carry_n,
  output logic          rf_we_req,
  output logic [W-1:0]  rf_wdata,
  output logic          bank_wr,
  output logic          bank_val
);
  logic [W:0] sum;

  always_comb begin
    acc_n     = acc_q;
    carry_n   = carry_q;
    rf_we_req = 1'b0;
    rf_wdata  = rd;
    bank_wr   = 1'b0;
    bank_val  = 1'b0;
    sum       = '0;
    unique case (opc)
      OP_NOP:   ;
      OP_LDI:   acc_n = imm;
      OP_LD:    acc_n = rd;
      OP_XCH: begin
        acc_n     = rd;
        rf_we_req = 1'b1;
        rf_wdata  = acc_q;
      end
      OP_ADD: begin
        sum     = add_ci(acc_q, rd, carry_q);
        acc_n   = sum[W-1:0];
        carry_n = sum[W];
      end
      OP_SUB: begin
        sum     = sub_nb(acc_q, rd, carry_q);
        acc_n   = sum[W-1:0];
        carry_n = sum[W];
      end
      OP_INC: begin
        rf_we_req = 1'b1;
        rf_wdata  = rd + W'(1);
      end
      OP_OR_A, OP_OR_B:   acc_n = acc_q | rd;
      OP_AND_A, OP_AND_B: acc_n = acc_q & rd;
      OP_CONV:  acc_n = onehot_code(acc_q);
      OP_BANK0: begin bank_wr = 1'b1; bank_val = 1'b0; end
      OP_BANK1: begin bank_wr = 1'b1; bank_val = 1'b1; end
      OP_CLRC:  carry_n = 1'b0;
      OP_SETC:  carry_n = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/acc4_core.sv
module acc4_core
  import acc_pkg::*;
#(
  parameter int unsigned NREG       = 16,
  parameter int unsigned NBANK      = 8,
  parameter int unsigned LOGIC_BASE = 4,
  localparam int unsigned AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_en,
  input  logic [3:0]    op,
  input  logic [AW-1:0] reg_sel,
  output logic [DW-1:0] acc,
  output logic          carry
);
  op_e           opc;
  logic [DW-1:0] acc_q, acc_n;
  logic          carry_q, carry_n;
  logic          bank_q;
  logic [AW-1:0] rf_sel;
  logic [DW-1:0] rd_data;
  logic          rf_we_req, rf_we;
  logic [DW-1:0] rf_wdata;
  logic          bank_wr, bank_val;

  assign opc = op_e'(op);

  // logic operations read a fixed register, others the selected one
  always_comb begin
    unique case (opc)
      OP_OR_A:  rf_sel = AW'(LOGIC_BASE);
      OP_OR_B:  rf_sel = AW'(LOGIC_BASE + 1);
      OP_AND_A: rf_sel = AW'(LOGIC_BASE + 2);
      OP_AND_B: rf_sel = AW'(LOGIC_BASE + 3);
      default:  rf_sel = reg_sel;
    endcase
  end

  acc_alu #(.W(DW)) u_alu (
    .opc       (opc),
    .acc_q     (acc_q),
    .carry_q   (carry_q),
    .rd        (rd_data),
    .imm       (DW'(reg_sel)),
    .acc_n     (acc_n),
    .carry_n   (carry_n),
    .rf_we_req (rf_we_req),
    .rf_wdata  (rf_wdata),
    .bank_wr   (bank_wr),
    .bank_val  (bank_val)
  );

  assign rf_we = exec_en && rf_we_req;

  acc_rf #(.DW(DW), .NREG(NREG), .NBANK(NBANK)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .bank    (bank_q),
    .sel     (rf_sel),
    .rd_data (rd_data),
    .we      (rf_we),
    .wdata   (rf_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
      bank_q  <= 1'b0;
    end else if (exec_en) begin
      acc_q   <= acc_n;
      carry_q <= carry_n;
      if (bank_wr) bank_q <= bank_val;
    end
  end

  assign acc   = acc_q;
  assign carry = carry_q;

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> ($stable(acc_q) && $stable(carry_q) && $stable(bank_q)));

  assert_idle_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |-> !rf_we);

  assert_sub_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opc == OP_SUB && rd_data == acc_q && carry_q) |=> (carry_q && acc_q == '0));

  assert_inc_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && opc == OP_INC && rd_data == '1) |-> (rf_wdata == '0));

  assert_logic_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && (opc == OP_OR_A || opc == OP_OR_B || opc == OP_AND_A || opc == OP_AND_B))
      |=> $stable(carry_q));

  assert_conv_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opc == OP_CONV && $onehot0(acc_q)) |=> (acc_q != '1));

  assert_bank_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opc == OP_BANK1) |=> bank_q);

  assert_bank_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opc == OP_BANK0) |=> !bank_q);
endmodule

// File: tb/tb_acc4_core.sv
`timescale 1ns/1ps
module tb_acc4_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec_en = 1'b0;
  logic [3:0] op = 4'd0;
  logic [3:0] reg_sel = 4'd0;
  logic [3:0] acc;
  logic       carry;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model: 8 banked entries per bank plus 8 shared
  logic [3:0] m_b0 [8];
  logic [3:0] m_b1 [8];
  logic [3:0] m_sh [8];
  logic [3:0] m_acc;
  logic       m_c;
  logic       m_bank;

  always #2.5 clk = ~clk;

  acc4_core dut (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op(op),
    .reg_sel(reg_sel), .acc(acc), .carry(carry)
  );

  function automatic logic [3:0] m_get(input int n);
    if (n >= 8)  return m_sh[n-8];
    if (m_bank)  return m_b1[n];
    return m_b0[n];
  endfunction

  function automatic void m_put(input int n, input logic [3:0] v);
    if (n >= 8)      m_sh[n-8] = v;
    else if (m_bank) m_b1[n] = v;
    else             m_b0[n] = v;
  endfunction

  function automatic logic [3:0] conv_ref(input logic [3:0] a);
    case (a)
      4'b0000: return 4'd0;
      4'b0001: return 4'd1;
      4'b0010: return 4'd2;
      4'b0100: return 4'd3;
      4'b1000: return 4'd4;
      default: return 4'd15;
    endcase
  endfunction

  function automatic string tag_of(input logic en, input int o);
    if (!en) return "R2";
    case (o)
      0: return "R12";
      1, 2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      7, 8, 9, 10: return "R8";
      11: return "R9";
      12, 13: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic void m_apply(input int o, input int s);
    int t;
    logic [3:0] r;
    r = m_get(s);
    case (o)
      1: m_acc = 4'(s);
      2: m_acc = r;
      3: begin m_put(s, m_acc); m_acc = r; end
      4: begin t = int'(m_acc) + int'(r) + int'(m_c); m_acc = 4'(t % 16); m_c = (t > 15); end
      5: begin t = int'(m_acc) + (15 - int'(r)) + int'(m_c); m_acc = 4'(t % 16); m_c = (t > 15); end
      6: m_put(s, (r == 4'd15) ? 4'd0 : r + 4'd1);
      7: m_acc = m_acc | m_get(4);
      8: m_acc = m_acc | m_get(5);
      9: m_acc = m_acc & m_get(6);
      10: m_acc = m_acc & m_get(7);
      11: m_acc = conv_ref(m_acc);
      12: m_bank = 1'b0;
      13: m_bank = 1'b1;
      14: m_c = 1'b0;
      15: m_c = 1'b1;
      default: ;
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] ea, input logic ec);
    total++;
    if (acc !== ea || carry !== ec) begin
      bad++;
      $display("FAIL %s acc=%0h exp=%0h carry=%0b exp=%0b", req, acc, ea, carry, ec);
    end
  endtask

  task automatic step(input logic en, input int o, input int s, input string req);
    @(negedge clk);
    exec_en = en; op = 4'(o); reg_sel = 4'(s);
    @(posedge clk);
    if (en) m_apply(o, s);
    #1;
    check((req == "") ? tag_of(en, o) : req, m_acc, m_c);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) begin m_b0[i] = 0; m_b1[i] = 0; m_sh[i] = 0; end
    m_acc = 0; m_c = 0; m_bank = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", 4'd0, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    // R1: every register reads zero in bank 0, then bank 1
    for (int r = 0; r < 16; r++) step(1, 2, r, "R1");
    step(1, 13, 0, "R10");
    for (int r = 0; r < 8; r++) step(1, 2, r, "R1");
    step(1, 12, 0, "R10");

    // R10: bank switch followed at once by access
    step(1, 1, 5, "R3");
    step(1, 3, 2, "R4");
    step(1, 1, 9, "R3");
    step(1, 3, 10, "R4");
    step(1, 13, 0, "R10");
    step(1, 2, 2, "R10");
    step(1, 2, 10, "R10");
    step(1, 1, 7, "R3");
    step(1, 3, 2, "R10");
    step(1, 12, 0, "R10");
    step(1, 2, 2, "R10");

    // R4: exchange on a register that was written the cycle before
    step(1, 6, 2, "R7");
    step(1, 3, 2, "R4");
    step(1, 3, 2, "R4");

    // R7: wrap of 15 to 0
    step(1, 1, 15, "R3");
    step(1, 3, 11, "R4");
    step(1, 15, 0, "R11");
    step(1, 6, 11, "R7");
    step(1, 2, 11, "R7");

    // R5/R6 corners
    step(1, 1, 15, "R3");
    step(1, 4, 11, "R5");
    step(1, 15, 0, "R11");
    step(1, 1, 3, "R3");
    step(1, 3, 12, "R4");
    step(1, 1, 3, "R3");
    step(1, 5, 12, "R6");
    step(1, 14, 0, "R11");
    step(1, 5, 12, "R6");
    step(1, 1, 0, "R3");
    step(1, 15, 0, "R11");
    step(1, 5, 2, "R6");

    // R8: fixed operands, reg_sel ignored
    for (int r = 4; r < 8; r++) begin
      step(1, 1, 1 << (r - 4), "R3");
      step(1, 3, r, "R4");
    end
    step(1, 1, 0, "R3");
    step(1, 7, 13, "R8");
    step(1, 8, 0, "R8");
    step(1, 1, 15, "R3");
    step(1, 9, 3, "R8");
    step(1, 1, 15, "R3");
    step(1, 10, 9, "R8");

    // R9: all sixteen inputs
    for (int v = 0; v < 16; v++) begin
      step(1, 1, v, "R3");
      step(1, 11, 0, "R9");
    end

    // R2 and R12
    step(1, 1, 6, "R3");
    step(0, 3, 2, "R2");
    step(0, 13, 0, "R2");
    step(0, 6, 2, "R2");
    step(1, 0, 2, "R12");
    step(1, 2, 2, "R2");

    // seeded random mix
    for (int k = 0; k < 3000; k++) begin
      int o, s;
      logic en;
      o = int'($urandom_range(0, 15));
      s = int'($urandom_range(0, 15));
      en = ($urandom_range(0, 7) != 0);
      step(en, o, s, "");
    end
    for (int r = 0; r < 16; r++) step(1, 2, r, "R10");

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule